// File: doc/BRIEF.md
# Push-Button Wiper Controller with Shutdown

This block sets the tap of a digital potentiometer from two active-low push buttons, one raising and one lowering the code, and an active-low store button that is only used to wake the block. Each button press that survives the debounce time moves the 7-bit wiper code by one step. Holding a button long enough starts auto-repeat stepping at a fixed period until the button is released. Holding both buttons together for two seconds puts the block into a shutdown state. In that state the high terminal is disconnected and the wiper is parked at code 0. A later debounced press of any button leaves shutdown and brings back the code held before entry. All timing counts a one-clock tick enable that pulses once per millisecond, and every threshold is a parameter.

Button inputs pass through a two-flop synchronizer. A state machine then walks these states. IDLE: nothing pressed. PRESS: one button held, with the debounce step and the auto-repeat start timed from the press. REPEAT: periodic stepping. DUAL: both buttons held inside the coincidence window, counting toward shutdown. LOCK: commands ignored until every button is released. SHDN_REL: shut down, waiting for the entry gesture to be released. SHDN: shut down and armed for wake. WAKE: a wake press is being timed.

The transitions are as follows. IDLE goes to PRESS on one button, or to DUAL on both. PRESS goes to IDLE on release, to REPEAT at the auto-repeat threshold, to DUAL if the other button arrives inside the window, and to LOCK if it arrives later. REPEAT goes to IDLE on release, or to LOCK if the other button arrives. DUAL goes to SHDN_REL when the shutdown time elapses, or to LOCK when either button is released first. LOCK goes to IDLE once all buttons are released. SHDN_REL goes to SHDN once all buttons are released. SHDN goes to WAKE on any press. WAKE goes back to SHDN on an early release, or to LOCK once the debounce time completes.

Top module: `button_wiper_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the wiper code to 64, drives the high-terminal connect output to 1 and the shutdown flag to 0.
- R2: Outside shutdown, holding only the up button low for at least 15 ticks raises the code by exactly one, and doing the same with the down button lowers it by exactly one. The step lands on the 15th tick.
- R3: A press shorter than 15 ticks, including any bounce pulse, leaves the code unchanged.
- R4: The code saturates at 0 and at 127 and never wraps.
- R5: A press held for at least 250 ticks adds one more step on the 250th tick and one every 50 ticks after that. Stepping stops as soon as the button is released. A hold of n ticks therefore gives 2 + (n-250)/50 steps, with integer division.
- R6: If the second button falls fewer than 15 ticks after the first, both buttons count as one simultaneous press. Once both have been held together for 2000 ticks, the block is in shutdown: the shutdown flag is 1, the connect output is 0 and the wiper code is 0.
- R7: If the second button falls 15 or more ticks after the first, no shutdown results. After any step already made, no further step occurs until both buttons have been released.
- R8: In shutdown, after all buttons have been released, holding up, down or store low for 15 ticks leaves shutdown. The connect output returns to 1 and the code returns to the value held before entry.
- R9: The press that wakes the block makes no step, even when held past the auto-repeat threshold. Commands are ignored until all buttons have been released.
- R10: Outside shutdown, the store button has no effect on the code.
- R11: In shutdown, a wake press shorter than 15 ticks leaves the block in shutdown.
- R12: If both buttons are released before the 2000 ticks elapse, the simultaneous press ends with no shutdown and no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-clock pulse once per millisecond |
| up_n_i | input | 1 | Raise button, active low, asynchronous |
| dn_n_i | input | 1 | Lower button, active low, asynchronous |
| store_n_i | input | 1 | Store button, active low, used for wake |
| wiper_o | output | 7 | Wiper tap code |
| hi_conn_o | output | 1 | High terminal connected when 1 |
| shdn_o | output | 1 | Shutdown status |

## Verification
A button edge reaches the state machine three clock edges after it is driven. The bench changes buttons on the falling edge just after a tick edge, and ticks come every fourth clock, so every tick the bench waits is counted by the block. Each step, the shutdown entry and the wake restore appear on the rising edge that carries the deciding tick. The bench reads the outputs on the falling edge right after that tick, so boundary checks fall exactly at ticks 14/15, 249/250/300 and 1999/2000. Expected codes come from a saturating step-count function of the hold length.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRESS,
        S_REPEAT,
        S_DUAL,
        S_LOCK,
        S_SHDN_REL,
        S_SHDN,
        S_WAKE
    } wpc_state_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_UP,
        DIR_DN
    } wpc_dir_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_n_i,
    output logic [WIDTH-1:0] sync_n_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b1;
                stab_q[g] <= 1'b1;
            end else begin
                meta_q[g] <= async_n_i[g];
                stab_q[g] <= meta_q[g];
            end
        end
    end

    assign sync_n_o = stab_q;

endmodule

// File: rtl/wpc_tick_timer.sv
module wpc_tick_timer #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] cnt_o
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/wpc_wiper.sv
module wpc_wiper #(
    parameter int WIPER_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc_i,
    input  logic               dec_i,
    output logic [WIPER_W-1:0] pos_o
);

    localparam logic [WIPER_W-1:0] POS_MAX = '1;
    localparam logic [WIPER_W-1:0] POS_MID = WIPER_W'(1) << (WIPER_W - 1);

    logic [WIPER_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_MID;
        end else if (inc_i && (pos_q != POS_MAX)) begin
            pos_q <= pos_q + 1'b1;
        end else if (dec_i && (pos_q != '0)) begin
            pos_q <= pos_q - 1'b1;
        end
    end

    assign pos_o = pos_q;

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inc_i, dec_i})); // R2
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && pos_q == POS_MAX) |=> (pos_q == POS_MAX)); // R4
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (dec_i && pos_q == '0) |=> (pos_q == '0)); // R4
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !dec_i) |=> $stable(pos_q)); // R3

endmodule

// File: rtl/button_wiper_ctrl.sv
module button_wiper_ctrl
    import wpc_pkg::*;
#(
    parameter int WIPER_W        = 7,
    parameter int DEBOUNCE_TICKS = 15,
    parameter int COINC_TICKS    = 15,
    parameter int AUTO_TICKS     = 250,
    parameter int REPEAT_TICKS   = 50,
    parameter int SHDN_TICKS     = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               up_n_i,
    input  logic               dn_n_i,
    input  logic               store_n_i,
    output logic [WIPER_W-1:0] wiper_o,
    output logic               hi_conn_o,
    output logic               shdn_o
);

    localparam int TMR_MAX = imax(imax(DEBOUNCE_TICKS, COINC_TICKS),
                                  imax(imax(AUTO_TICKS, REPEAT_TICKS), SHDN_TICKS));
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    localparam logic [TMR_W-1:0] DEB_LAST   = TMR_W'(DEBOUNCE_TICKS - 1);
    localparam logic [TMR_W-1:0] AUTO_LAST  = TMR_W'(AUTO_TICKS - 1);
    localparam logic [TMR_W-1:0] REP_LAST   = TMR_W'(REPEAT_TICKS - 1);
    localparam logic [TMR_W-1:0] SHDN_LAST  = TMR_W'(SHDN_TICKS - 1);
    localparam logic [TMR_W-1:0] COINC_LIM  = TMR_W'(COINC_TICKS);

    wpc_state_e state_q, state_d;
    wpc_dir_e   dir_q, dir_d;

    logic [2:0]         sync_n;
    logic               up_p, dn_p, st_p, any_p, own_p, other_p;
    logic [TMR_W-1:0]   tcnt;
    logic               tmr_clr, rep_wrap, step;
    logic               hit_deb, hit_auto, hit_rep, hit_shdn;
    logic               inc, dec;
    logic [WIPER_W-1:0] pos;
    logic               parked;

    wpc_sync #(.WIDTH(3)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_n_i({store_n_i, dn_n_i, up_n_i}),
        .sync_n_o (sync_n)
    );

    assign up_p    = ~sync_n[0];
    assign dn_p    = ~sync_n[1];
    assign st_p    = ~sync_n[2];
    assign any_p   = up_p | dn_p | st_p;
    assign own_p   = (dir_q == DIR_UP) ? up_p : dn_p;
    assign other_p = (dir_q == DIR_UP) ? dn_p : up_p;

    wpc_tick_timer #(.WIDTH(TMR_W)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick_i),
        .clr_i (tmr_clr),
        .cnt_o (tcnt)
    );

    assign hit_deb  = tick_i && (tcnt == DEB_LAST);
    assign hit_auto = tick_i && (tcnt == AUTO_LAST);
    assign hit_rep  = tick_i && (tcnt == REP_LAST);
    assign hit_shdn = tick_i && (tcnt == SHDN_LAST);

    // next-state and step decisions
    always_comb begin
        state_d  = state_q;
        dir_d    = dir_q;
        step     = 1'b0;
        rep_wrap = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (up_p && dn_p) begin
                    state_d = S_DUAL;
                end else if (up_p) begin
                    state_d = S_PRESS;
                    dir_d   = DIR_UP;
                end else if (dn_p) begin
                    state_d = S_PRESS;
                    dir_d   = DIR_DN;
                end
            end
            S_PRESS: begin
                if (other_p) begin
                    state_d = (tcnt < COINC_LIM) ? S_DUAL : S_LOCK;
                end else if (!own_p) begin
                    state_d = S_IDLE;
                end else if (hit_auto) begin
                    state_d = S_REPEAT;
                    step    = 1'b1;
                end else if (hit_deb) begin
                    step    = 1'b1;
                end
            end
            S_REPEAT: begin
                if (other_p) begin
                    state_d = S_LOCK;
                end else if (!own_p) begin
                    state_d = S_IDLE;
                end else if (hit_rep) begin
                    step     = 1'b1;
                    rep_wrap = 1'b1;
                end
            end
            S_DUAL: begin
                if (!up_p || !dn_p) begin
                    state_d = S_LOCK;
                end else if (hit_shdn) begin
                    state_d = S_SHDN_REL;
                end
            end
            S_LOCK: begin
                if (!any_p) state_d = S_IDLE;
            end
            S_SHDN_REL: begin
                if (!any_p) state_d = S_SHDN;
            end
            S_SHDN: begin
                if (any_p) state_d = S_WAKE;
            end
            S_WAKE: begin
                if (!any_p) begin
                    state_d = S_SHDN;
                end else if (hit_deb) begin
                    state_d = S_LOCK;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign tmr_clr = (state_d != state_q) || rep_wrap;
    assign inc     = step && (dir_q == DIR_UP);
    assign dec     = step && (dir_q == DIR_DN);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            dir_q   <= DIR_NONE;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // the step register keeps the code while parked, so wake restores it
    wpc_wiper #(.WIPER_W(WIPER_W)) i_wiper (
        .clk  (clk),
        .rst  (rst),
        .inc_i(inc),
        .dec_i(dec),
        .pos_o(pos)
    );

    // outputs
    always_comb begin
        unique case (state_q)
            S_SHDN_REL, S_SHDN, S_WAKE: parked = 1'b1;
            default:                    parked = 1'b0;
        endcase
        shdn_o    = parked;
        hi_conn_o = ~parked;
        wiper_o   = parked ? '0 : pos;
    end

    AST_STEP_ONLY_HELD: assert property (@(posedge clk) disable iff (rst)
        (inc || dec) |-> (state_q == S_PRESS || state_q == S_REPEAT)); // R9
    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOCK && any_p) |=> (state_q == S_LOCK)); // R7
    AST_SHDN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DUAL && up_p && dn_p && hit_shdn) |=> (shdn_o && !hi_conn_o)); // R6
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAKE && any_p && hit_deb) |=> (!shdn_o && hi_conn_o)); // R8
    AST_WAKE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAKE && !any_p) |=> shdn_o); // R11
    AST_RESTORE_CODE: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn_o) |-> (wiper_o == $past(pos))); // R8

endmodule

// File: tb/test_button_wiper_ctrl.sv
module test_button_wiper_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic       st_n = 1'b1;
    logic [6:0] wiper;
    logic       hi_conn;
    logic       shdn;
    logic [1:0] tdiv = 2'd0;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  expv   = 64;
    int  saved  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    button_wiper_ctrl i_button_wiper_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .up_n_i   (up_n),
        .dn_n_i   (dn_n),
        .store_n_i(st_n),
        .wiper_o  (wiper),
        .hi_conn_o(hi_conn),
        .shdn_o   (shdn)
    );

    function automatic int steps_for(input int n);
        if (n < 15)  return 0;
        if (n < 250) return 1;
        return 2 + (n - 250) / 50;
    endfunction

    function automatic int sat(input int p, input int d);
        int r;
        r = p + d;
        if (r < 0)   r = 0;
        if (r > 127) r = 127;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic next_tick();
        do @(posedge clk); while (tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) next_tick();
    endtask

    task automatic release_all();
        up_n = 1'b1;
        dn_n = 1'b1;
        st_n = 1'b1;
        wait_ticks(2);
    endtask

    task automatic press(input bit is_up, input int n);
        if (is_up) up_n = 1'b0; else dn_n = 1'b0;
        wait_ticks(n);
        release_all();
        expv = sat(expv, is_up ? steps_for(n) : -steps_for(n));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset code", int'(wiper), 64);
        chk("R1 reset connect", int'(hi_conn), 1);
        chk("R1 reset shutdown", int'(shdn), 0);
        next_tick();

        // single steps and short presses
        press(1'b1, 15);
        chk("R2 up step", int'(wiper), expv);
        press(1'b0, 40);
        chk("R2 down step", int'(wiper), expv);
        press(1'b1, 14);
        chk("R3 short press", int'(wiper), 64);
        for (int i = 0; i < 4; i++) press(1'b0, 1 + i * 3);
        chk("R3 bounce burst", int'(wiper), 64);

        // auto-repeat boundaries
        up_n = 1'b0;
        wait_ticks(249);
        chk("R5 before repeat", int'(wiper), 65);
        wait_ticks(1);
        chk("R5 repeat start", int'(wiper), 66);
        wait_ticks(49);
        chk("R5 mid period", int'(wiper), 66);
        wait_ticks(1);
        chk("R5 period step", int'(wiper), 67);
        release_all();
        wait_ticks(60);
        chk("R5 stop on release", int'(wiper), 67);
        expv = 67;

        // saturation
        press(1'b1, 3800);
        chk("R4 top", int'(wiper), 127);
        press(1'b1, 20);
        chk("R4 top hold", int'(wiper), 127);
        press(1'b0, 6600);
        chk("R4 bottom", int'(wiper), 0);
        press(1'b0, 20);
        chk("R4 bottom hold", int'(wiper), 0);
        press(1'b1, 400);
        chk("R5 long hold count", int'(wiper), 5);

        // store outside shutdown
        st_n = 1'b0;
        wait_ticks(300);
        release_all();
        chk("R10 store ignored", int'(wiper), expv);

        // late second button: one step, then locked
        up_n = 1'b0;
        wait_ticks(20);
        dn_n = 1'b0;
        wait_ticks(2100);
        chk("R7 no shutdown", int'(shdn), 0);
        chk("R7 one step only", int'(wiper), 6);
        up_n = 1'b1;
        wait_ticks(100);
        chk("R7 down ignored in lock", int'(wiper), 6);
        release_all();
        expv = 6;
        press(1'b1, 20);
        chk("R7 commands after release", int'(wiper), 7);

        // simultaneous press released early
        up_n = 1'b0;
        dn_n = 1'b0;
        wait_ticks(100);
        release_all();
        chk("R12 no shutdown", int'(shdn), 0);
        chk("R12 no step", int'(wiper), 7);

        // staggered press inside window, shutdown boundary
        saved = 7;
        up_n = 1'b0;
        wait_ticks(10);
        dn_n = 1'b0;
        wait_ticks(1999);
        chk("R6 not yet", int'(shdn), 0);
        wait_ticks(1);
        chk("R6 shutdown flag", int'(shdn), 1);
        chk("R6 disconnect", int'(hi_conn), 0);
        chk("R6 parked", int'(wiper), 0);
        release_all();
        st_n = 1'b0;
        wait_ticks(14);
        release_all();
        chk("R11 short wake", int'(shdn), 1);
        st_n = 1'b0;
        wait_ticks(15);
        chk("R8 wake by store", int'(shdn), 0);
        chk("R8 reconnect", int'(hi_conn), 1);
        chk("R8 restored", int'(wiper), saved);
        release_all();

        // simultaneous press, wake with a long down hold
        up_n = 1'b0;
        dn_n = 1'b0;
        wait_ticks(2000);
        chk("R6 simultaneous", int'(shdn), 1);
        release_all();
        dn_n = 1'b0;
        wait_ticks(300);
        chk("R9 wake makes no step", int'(wiper), saved);
        chk("R8 wake by down", int'(shdn), 0);
        release_all();
        expv = saved;

        // random presses
        for (int it = 0; it < 30; it++) begin
            int kind;
            int len;
            bit dir;
            kind = int'($urandom_range(0, 3));
            dir  = 1'($urandom_range(0, 1));
            unique case (kind)
                0: len = int'($urandom_range(1, 14));
                1: len = int'($urandom_range(15, 249));
                2: len = int'($urandom_range(250, 450));
                default: len = int'($urandom_range(1, 300));
            endcase
            if (kind == 3) begin
                st_n = 1'b0;
                wait_ticks(len);
                release_all();
                chk("R10 random store", int'(wiper), expv);
            end else begin
                press(dir, len);
                if (kind == 0) chk("R3 random short", int'(wiper), expv);
                else if (kind == 1) chk("R2 random step", int'(wiper), expv);
                else chk("R5 random repeat", int'(wiper), expv);
            end
            wait_ticks(int'($urandom_range(0, 5)));
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule